// File: doc/BRIEF.md
# Three-Level PWM Gate Sequencer

This block is the digital control core of a synchronous buck half-bridge. Each cycle it takes an already decoded three-level PWM command and a three-level skip-mode selector, an enable qualifier and a synchronous zero-cross flag from the switch-node comparator. From these it produces the high-side and low-side gate commands. Every turn-on waits for a dead time after the opposite gate has turned off. Both dead times, the debounce interval and the blanking interval are parameters, counted in system clock cycles.

A mid-level PWM command has one of two meanings, and the skip-mode selector picks between them. When the selector is not low, the mid level starts diode emulation. The high side is released and the low side is held on through a combined debounce-plus-blanking window. After the window the low side waits for the zero-cross flag and is then released. When the selector is low, the mid level means the controller has already found zero current, and both gates are dropped at once.

Inputs are two-bit level codes: 00 is LOW, 01 is MID, 10 is HIGH, and 11 is read as MID. Wherever a requirement below says "edge N", N counts rising clock edges from the edge that samples the input change, which is edge 1.

Top module: `tri_pwm_gate_seq`

## Requirements
- R1: While reset is asserted, and after reset is released with PWM at MID and skip-mode LOW, both gate outputs are 0.
- R2: When PWM becomes HIGH (code 10) while enabled, the low-side output is 0 after edge 1. The high-side output rises at edge NOL_LEAD+1, with both outputs 0 in every cycle before that.
- R3: When PWM becomes LOW (code 00) while enabled, the high-side output is 0 after edge 1. The low-side output rises at edge NOL_TRAIL+1.
- R4: With skip-mode not LOW and PWM entering MID (code 01 or 11), the high side is released at edge 1. The low side turns on at edge NOL_TRAIL+1, or stays on with no gap if it was already on. It is then held on for DEBOUNCE+BLANK cycles whatever the zero-cross flag does.
- R5: Once that window has ended and PWM is still MID, the low side is held on until the zero-cross flag is sampled high. It is 0 from the next edge.
- R6: A zero-cross flag seen at any point during the window does not shorten the window. The low side is released exactly at edge DEBOUNCE+BLANK+1 after the edge that entered the window.
- R7: With skip-mode LOW (code 00) and PWM at MID, both outputs are 0 from the next edge, from any state, with no dead time.
- R8: Skip-mode MID (code 01) behaves exactly like skip-mode HIGH (code 10).
- R9: If skip-mode changes to LOW while the low side is on, the low side is 0 from that edge on. It stays off until PWM moves to a different level. The same change while the high side is on has no effect.
- R10: While the enable input is 0, both outputs are 0 from the next edge. When enable returns, the outputs follow PWM again through the normal dead time.
- R11: The high-side and low-side outputs are never 1 in the same cycle.
- R12: After a zero-cross or skip-mode release, both outputs stay 0 until PWM leaves the level it held at the release. A later entry into MID starts a full new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable qualifier; 0 forces both gates off |
| pwm_code | input | 2 | Decoded PWM level (00 LOW, 01/11 MID, 10 HIGH) |
| skip_code | input | 2 | Decoded skip-mode level (00 LOW, 01/11 MID, 10 HIGH) |
| zc_det | input | 1 | Synchronous zero-cross comparator flag |
| hs_on | output | 1 | High-side gate command |
| ls_on | output | 1 | Low-side gate command |

## Verification
The bench builds the block with dead times of 2 and 3 cycles, a 2-cycle debounce and a 3-cycle blanking interval. The two dead times differ, so a swap between them shows up as a one-cycle timing error. The 5-cycle window is short enough to probe a zero-cross pulse in its middle and to check the exact release edge. A sweep covers every pair of PWM levels under skip-mode HIGH and LOW and compares the settled gate pair against the expected value. Directed sequences cover the skip-mode falling edge, the enable drop and re-entry into the window after a release.

// File: rtl/tpgs_pkg.sv
package tpgs_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NOL_HS,
    ST_HS,
    ST_NOL_LS,
    ST_LS,
    ST_WIN,
    ST_WATCH,
    ST_PARK
  } st_t;

  // total low-side hold after a mid-level entry
  function automatic int unsigned window_cycles(int unsigned deb, int unsigned blank);
    return deb + blank;
  endfunction

  // counter width able to hold maxv
  function automatic int unsigned cnt_width(int unsigned maxv);
    if (maxv < 2) return 1;
    return $clog2(maxv + 1);
  endfunction

  // two-bit level code to level; the unused code reads as mid
  function automatic lvl_t norm_lvl(logic [1:0] code);
    case (code)
      2'b00:   return LVL_LOW;
      2'b10:   return LVL_HIGH;
      default: return LVL_MID;
    endcase
  endfunction

endpackage

// File: rtl/tpgs_level_decode.sv
module tpgs_level_decode
  import tpgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_code,
  input  logic [1:0] skip_code,
  output lvl_t       pwm_lvl,
  output logic       skip_low,
  output logic       skip_fall
);

  logic skip_low_q;

  assign pwm_lvl   = norm_lvl(pwm_code);
  assign skip_low  = (norm_lvl(skip_code) == LVL_LOW);
  // mid and high are equal for the logic; only entry into low is an edge
  assign skip_fall = skip_low && !skip_low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) skip_low_q <= 1'b0;
    else        skip_low_q <= skip_low;
  end

endmodule

// File: rtl/tpgs_delay_timer.sv
module tpgs_delay_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  assign done = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

endmodule

// File: rtl/tpgs_gate_fsm.sv
module tpgs_gate_fsm
  import tpgs_pkg::*;
#(
  parameter int NOL_LEAD  = 2,
  parameter int NOL_TRAIL = 3,
  parameter int WIN_LEN   = 5,
  parameter int NOL_W     = 2,
  parameter int WIN_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  lvl_t             pwm_lvl,
  input  logic             skip_low,
  input  logic             skip_fall,
  input  logic             zc_det,
  input  logic             nol_done,
  input  logic             win_done,
  output logic             nol_load,
  output logic [NOL_W-1:0] nol_val,
  output logic             win_load,
  output logic [WIN_W-1:0] win_val,
  output logic             hs_on,
  output logic             ls_on
);

  localparam logic [NOL_W-1:0] LEAD_V  = NOL_W'(NOL_LEAD - 1);
  localparam logic [NOL_W-1:0] TRAIL_V = NOL_W'(NOL_TRAIL - 1);
  localparam logic [WIN_W-1:0] WIN_V   = WIN_W'(WIN_LEN - 1);

  st_t  st, nxt;
  lvl_t park_lvl, park_nxt;
  logic zc_seen;

  // named events
  logic mid_cut;     // mid level with skip low: drop both gates
  logic ls_active;   // low side currently commanded on
  logic cut_ls;      // skip fall releases the low side
  logic zc_release;  // window or watch ends through zero cross
  st_t  entry_st;    // state reached when starting from rest

  assign mid_cut    = (pwm_lvl == LVL_MID) && skip_low;
  assign ls_active  = (st == ST_LS) || (st == ST_WIN) || (st == ST_WATCH);
  assign cut_ls     = skip_fall && ls_active;
  assign zc_release = (st == ST_WIN)   ? (win_done && (zc_seen || zc_det)) :
                      (st == ST_WATCH) ? zc_det : 1'b0;
  assign entry_st   = (pwm_lvl == LVL_HIGH) ? ST_NOL_HS : ST_NOL_LS;

  always_comb begin
    nxt      = st;
    park_nxt = park_lvl;
    if (!en || mid_cut) begin
      nxt = ST_IDLE;
    end else if (cut_ls) begin
      nxt      = ST_PARK;
      park_nxt = pwm_lvl;
    end else begin
      case (st)
        ST_IDLE: nxt = entry_st;
        ST_NOL_HS: begin
          if (pwm_lvl != LVL_HIGH) nxt = ST_NOL_LS;
          else if (nol_done)       nxt = ST_HS;
        end
        ST_HS: begin
          if (pwm_lvl != LVL_HIGH) nxt = ST_NOL_LS;
        end
        ST_NOL_LS: begin
          if (pwm_lvl == LVL_HIGH) nxt = ST_NOL_HS;
          else if (nol_done)       nxt = (pwm_lvl == LVL_LOW) ? ST_LS : ST_WIN;
        end
        ST_LS: begin
          if (pwm_lvl == LVL_HIGH)     nxt = ST_NOL_HS;
          else if (pwm_lvl == LVL_MID) nxt = ST_WIN;
        end
        ST_WIN, ST_WATCH: begin
          if (pwm_lvl == LVL_HIGH)     nxt = ST_NOL_HS;
          else if (pwm_lvl == LVL_LOW) nxt = ST_LS;
          else if (zc_release) begin
            nxt      = ST_PARK;
            park_nxt = LVL_MID;
          end else if (st == ST_WIN && win_done) begin
            nxt = ST_WATCH;
          end
        end
        ST_PARK: begin
          if (pwm_lvl != park_lvl) nxt = entry_st;
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  // timers restart on every entry into their state
  assign nol_load = ((nxt == ST_NOL_HS) || (nxt == ST_NOL_LS)) && (nxt != st);
  assign nol_val  = (nxt == ST_NOL_HS) ? LEAD_V : TRAIL_V;
  assign win_load = (nxt == ST_WIN) && (st != ST_WIN);
  assign win_val  = WIN_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      park_lvl <= LVL_MID;
      zc_seen  <= 1'b0;
    end else begin
      st       <= nxt;
      park_lvl <= park_nxt;
      if (st != ST_WIN)  zc_seen <= 1'b0;
      else if (zc_det)   zc_seen <= 1'b1;
    end
  end

  assign hs_on = (st == ST_HS);
  assign ls_on = ls_active;

  // R10: enable low drops both gates
  p_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_on && !ls_on));

  // R7: mid level under skip low cuts both gates at once
  p_mid_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pwm_lvl == LVL_MID && skip_low) |=> (!hs_on && !ls_on));

  // R2: high side turns on only after a cycle with the low side off
  p_hs_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> !$past(ls_on));

  // R3: low side turns on only after a cycle with the high side off
  p_ls_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> !$past(hs_on));

  // R9: skip fall with the low side on releases it
  p_skip_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_fall && ls_on) |=> !ls_on);

  // R6: zero cross inside the window does not end it
  p_win_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WIN && !win_done && en && pwm_lvl == LVL_MID && !skip_low) |=> ls_on);

  // R5: zero cross after the window releases the low side
  p_zc_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WATCH && zc_det && en && pwm_lvl == LVL_MID) |=> !ls_on);

endmodule

// File: rtl/tri_pwm_gate_seq.sv
module tri_pwm_gate_seq
  import tpgs_pkg::*;
#(
  parameter int NOL_LEAD  = 2,
  parameter int NOL_TRAIL = 3,
  parameter int DEBOUNCE  = 16,
  parameter int BLANK     = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] pwm_code,
  input  logic [1:0] skip_code,
  input  logic       zc_det,
  output logic       hs_on,
  output logic       ls_on
);

  localparam int WIN_LEN = int'(window_cycles(DEBOUNCE, BLANK));
  localparam int NOL_MAX = (NOL_LEAD > NOL_TRAIL) ? NOL_LEAD : NOL_TRAIL;
  localparam int NOL_W   = int'(cnt_width(NOL_MAX));
  localparam int WIN_W   = int'(cnt_width(WIN_LEN));

  lvl_t             pwm_lvl;
  logic             skip_low, skip_fall;
  logic             nol_load, win_load, nol_done, win_done;
  logic [NOL_W-1:0] nol_val;
  logic [WIN_W-1:0] win_val;

  tpgs_level_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_code  (pwm_code),
    .skip_code (skip_code),
    .pwm_lvl   (pwm_lvl),
    .skip_low  (skip_low),
    .skip_fall (skip_fall)
  );

  tpgs_delay_timer #(.W(NOL_W)) u_nol_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (nol_load),
    .load_val (nol_val),
    .done     (nol_done)
  );

  tpgs_delay_timer #(.W(WIN_W)) u_win_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (win_load),
    .load_val (win_val),
    .done     (win_done)
  );

  tpgs_gate_fsm #(
    .NOL_LEAD  (NOL_LEAD),
    .NOL_TRAIL (NOL_TRAIL),
    .WIN_LEN   (WIN_LEN),
    .NOL_W     (NOL_W),
    .WIN_W     (WIN_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .pwm_lvl   (pwm_lvl),
    .skip_low  (skip_low),
    .skip_fall (skip_fall),
    .zc_det    (zc_det),
    .nol_done  (nol_done),
    .win_done  (win_done),
    .nol_load  (nol_load),
    .nol_val   (nol_val),
    .win_load  (win_load),
    .win_val   (win_val),
    .hs_on     (hs_on),
    .ls_on     (ls_on)
  );

  // R11: gates never on together
  p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

endmodule

// File: tb/tb_tri_pwm_gate_seq.sv
`timescale 1ns/1ps
module tb_tri_pwm_gate_seq;

  localparam int P_LEAD  = 2;
  localparam int P_TRAIL = 3;
  localparam int P_DEB   = 2;
  localparam int P_BLANK = 3;
  localparam int WIN_C   = P_DEB + P_BLANK;

  localparam logic [1:0] C_LOW  = 2'b00;
  localparam logic [1:0] C_MID  = 2'b01;
  localparam logic [1:0] C_HIGH = 2'b10;

  logic clk = 1'b0;
  logic rst_n, en, zc_det;
  logic [1:0] pwm_code, skip_code;
  logic hs_on, ls_on;

  int n_chk = 0;
  int n_err = 0;
  int overlap_cnt = 0;

  always #2.5 clk = ~clk;

  tri_pwm_gate_seq #(
    .NOL_LEAD (P_LEAD), .NOL_TRAIL (P_TRAIL), .DEBOUNCE (P_DEB), .BLANK (P_BLANK)
  ) dut (
    .clk (clk), .rst_n (rst_n), .en (en), .pwm_code (pwm_code),
    .skip_code (skip_code), .zc_det (zc_det), .hs_on (hs_on), .ls_on (ls_on)
  );

  always @(negedge clk) if (rst_n && hs_on && ls_on) overlap_cnt++;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gates();
    return 2 * int'(hs_on) + int'(ls_on);
  endfunction

  // ticks until the chosen gate is seen on
  task automatic rise_after(input bit want_hs, output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (((want_hs ? hs_on : ls_on) == 1'b0) && n < 60);
  endtask

  // count cycles whose gate pair differs from expectation
  task automatic hold(input string req, input int cyc, input int exp_g);
    int bad = 0;
    repeat (cyc) begin
      tick();
      if (gates() != exp_g) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic zc_pulse();
    zc_det = 1'b1;
    tick();
    zc_det = 1'b0;
  endtask

  initial begin
    #500000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; en = 1'b1; zc_det = 1'b0;
    pwm_code = C_MID; skip_code = C_LOW;
    repeat (3) tick();
    chk("R1 gates in reset", gates(), 0);
    rst_n = 1'b1;
    hold("R1 gates after reset", 3, 0);

    // R3: low side after trailing dead time
    skip_code = C_HIGH; pwm_code = C_LOW;
    rise_after(1'b0, n);
    chk("R3 ls rise edge", n, P_TRAIL + 1);
    chk("R3 hs off", int'(hs_on), 0);

    // R2: low side off first, then high side
    pwm_code = C_HIGH;
    tick();
    chk("R2 ls off at first edge", gates(), 0);
    rise_after(1'b1, n);
    chk("R2 hs rise edge", n + 1, P_LEAD + 1);

    // R4/R5: mid entry from high side
    pwm_code = C_MID;
    tick();
    chk("R4 hs off at first edge", int'(hs_on), 0);
    rise_after(1'b0, n);
    chk("R4 ls rise edge", n + 1, P_TRAIL + 1);
    hold("R5 ls held past window", WIN_C + 4, 1);
    zc_pulse();
    chk("R5 ls off after zero cross", gates(), 0);
    hold("R12 parked while mid", 6, 0);

    // R12: leaving mid after release; R6 window exact with zc inside
    pwm_code = C_LOW;
    rise_after(1'b0, n);
    chk("R12 ls rise on leaving mid", n, P_TRAIL + 1);
    pwm_code = C_MID;
    tick();
    zc_pulse();
    hold("R6 ls held through window", WIN_C - 2, 1);
    tick();
    chk("R6 ls off at window end", gates(), 0);
    hold("R12 parked after window", 3, 0);

    // R12/R4: re-entry from low side rearms the window
    pwm_code = C_LOW;
    rise_after(1'b0, n);
    chk("R12 ls rise again", n, P_TRAIL + 1);
    pwm_code = C_MID;
    hold("R4 ls continuous on mid re-entry", WIN_C + 3, 1);
    zc_pulse();
    chk("R12 rearmed window releases on zc", gates(), 0);

    // R9: skip fall while low side on
    pwm_code = C_LOW;
    rise_after(1'b0, n);
    chk("R9 setup ls on", int'(ls_on), 1);
    skip_code = C_LOW;
    tick();
    chk("R9 ls off on skip fall", gates(), 0);
    hold("R9 ls stays off while pwm low", 4, 0);
    pwm_code = C_HIGH;
    rise_after(1'b1, n);
    chk("R9 hs after level change", n, P_LEAD + 1);

    // R9: skip fall while high side on is ignored
    skip_code = C_HIGH;
    hold("R9 hs steady", 2, 2);
    skip_code = C_LOW;
    hold("R9 hs ignores skip fall", 4, 2);

    // R7: mid under skip low from high and from low side
    pwm_code = C_MID;
    tick();
    chk("R7 both off from hs", gates(), 0);
    hold("R7 both stay off", 4, 0);
    pwm_code = C_LOW;
    rise_after(1'b0, n);
    chk("R7 ls under skip low", n, P_TRAIL + 1);
    pwm_code = C_MID;
    tick();
    chk("R7 both off from ls", gates(), 0);

    // R8: skip mid behaves like skip high
    skip_code = C_MID; pwm_code = C_HIGH;
    rise_after(1'b1, n);
    chk("R8 hs rise", n, P_LEAD + 1);
    pwm_code = C_MID;
    rise_after(1'b0, n);
    chk("R8 ls rise on mid", n, P_TRAIL + 1);
    hold("R8 ls held", WIN_C + 3, 1);
    zc_pulse();
    chk("R8 zc release", gates(), 0);

    // R10: enable
    pwm_code = C_HIGH;
    rise_after(1'b1, n);
    chk("R10 setup hs", n, P_LEAD + 1);
    en = 1'b0;
    tick();
    chk("R10 off at first edge", gates(), 0);
    hold("R10 stays off", 4, 0);
    en = 1'b1;
    rise_after(1'b1, n);
    chk("R10 hs after re-enable", n, P_LEAD + 1);

    // sweep every level pair under skip high and skip low
    for (int s = 0; s < 2; s++) begin
      pwm_code = C_HIGH;
      repeat (20) tick();
      skip_code = (s == 0) ? C_HIGH : C_LOW;
      repeat (4) tick();
      for (int a = 0; a < 3; a++) begin
        for (int b = 0; b < 3; b++) begin
          logic [1:0] ca, cb;
          int exp_g;
          ca = (a == 0) ? C_LOW : (a == 1) ? C_MID : C_HIGH;
          cb = (b == 0) ? C_LOW : (b == 1) ? C_MID : C_HIGH;
          pwm_code = ca;
          repeat (20) tick();
          pwm_code = cb;
          repeat (20) tick();
          if (b == 2)      exp_g = 2;
          else if (b == 0) exp_g = 1;
          else             exp_g = (s == 0) ? 1 : 0;
          if (b == 2)      chk("R2 sweep settled", gates(), exp_g);
          else if (b == 0) chk("R3 sweep settled", gates(), exp_g);
          else if (s == 0) chk("R4 sweep settled", gates(), exp_g);
          else             chk("R7 sweep settled", gates(), exp_g);
        end
      end
    end

    chk("R11 overlap cycles", overlap_cnt, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule